// File: doc/BRIEF.md
# Reset Source Aggregation Controller

This block gathers a set of reset request lines into one system reset. Each source has three settings held in registers: whether it takes part, whether the system reset waits for that source to let go, and whether it asks for a cold or a hot reset. A sticky cause register shows which sources brought about the last reset. Software clears that register bit by bit. A countdown register lets software schedule a reset of its own. The countdown is clocked by an external tick strobe and fires when its value reaches two.

Software reaches the block through a plain 32-bit register bus. The bus uses a byte address, word-aligned accesses and a read latency of one cycle. The block is cleared only by its own power-on reset input. The reset it drives leaves the cause record, the countdown and the settings as they are, so firmware can read the cause after the system comes back.

Top module: `rst_agg_ctrl`

## Requirements
- R1: Register words are selected by bus_addr[4:2]: 0 cause, 1 live status, 2 hold, 3 enable, 4 type, 7 countdown. Words 5 and 6 read zero. In cause, status, hold, enable and type only bits 0,1,4,5,8..11,16..19,24,30,31 (mask 0xC10F0F33) are stored or read back; all other bits read zero. Reads return data one cycle after the request.
- R2: Status bit i shows the live level of src_req[i] for bits 0,1,4,5,16..19,24,30. Bits 8..11 are tied to zero, src_req[31] is ignored, and status bit 31 is 1 exactly while the countdown holds the value 2.
- R3: A source whose enable bit is 0 still shows in status, but it never asserts sys_rst_o and never sets a cause bit.
- R4: A new enabled request (an enabled active source that was not active on the previous cycle) raises sys_rst_o on the next clock edge. Without a hold, sys_rst_o stays high for exactly MIN_PULSE cycles (16 by default).
- R5: If some enabled active source has its hold bit set, sys_rst_o stays high past the minimum pulse. It falls one clock edge after the last such source is released.
- R6: When a reset starts, every enabled active source sets its cause bit. Writing 1 to a cause bit clears it, and writing 0 leaves it unchanged.
- R7: rst_hot_o is 0 (cold) if any enabled active source at reset entry has a type bit of 0. It is 1 (hot) only when all of them have a type bit of 1. It is valid while sys_rst_o is high.
- R8: The countdown takes the written value. It decrements by one on each cycle that cnt_tick is high, stops at 0, and a bus write takes priority over a tick. Writing 0 before the value reaches 2 cancels the scheduled reset.
- R9: The cause and countdown registers are unaffected by sys_rst_o. Only rst restores the defaults: enable, hold and type all ones on the implemented bits, and cause and countdown zero.
- R10: A source left active after its reset completes does not start another reset until it has been released and raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cnt_tick | input | 1 | One-cycle strobe that advances the countdown |
| src_req | input | 32 | Live reset request lines, one bit per source |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| sys_rst_o | output | 1 | System reset request, registered |
| rst_hot_o | output | 1 | Reset type: 1 hot, 0 cold |

## Verification
The bench builds the block with MIN_PULSE left at 16 and a 5-bit address. With these values the exact pulse length can be counted cycle by cycle, and all eight register words, including both reserved ones, can be reached. The countdown is driven by bench-issued tick strobes rather than a free-running rate, so the bench can place the value 2 and a cancelling write on chosen cycles. Random writes to the three configuration words are checked against the implemented-bit mask.

// File: rtl/rst_agg_pkg.sv
package rst_agg_pkg;
  localparam int DW = 32;
  // bits that exist in the per-source registers
  localparam logic [DW-1:0] IMPL_MASK = 32'hC10F_0F33;
  // bits driven from external request pins (8..11 tied off, 31 is software)
  localparam logic [DW-1:0] PIN_MASK  = 32'h410F_0033;
  localparam int SW_BIT = 31;
  localparam logic [2:0] W_CAUSE  = 3'd0;
  localparam logic [2:0] W_STATUS = 3'd1;
  localparam logic [2:0] W_HOLD   = 3'd2;
  localparam logic [2:0] W_ENABLE = 3'd3;
  localparam logic [2:0] W_TYPE   = 3'd4;
  localparam logic [2:0] W_COUNT  = 3'd7;
  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_HOLD} seq_state_t;
endpackage

// File: rtl/rst_agg_swcnt.sv
module rst_agg_swcnt
  import rst_agg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] count,
  output logic          req
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (wr) count <= wdata;
    else if (tick && count != '0) count <= count - 1'b1;
  end

  assign req = (count == DW'(2));
endmodule

// File: rtl/rst_agg_regs.sv
module rst_agg_regs
  import rst_agg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     live,
  input  logic [DW-1:0]     set_flags,
  input  logic [DW-1:0]     count,
  output logic              count_wr,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     en_q,
  output logic [DW-1:0]     hold_q,
  output logic [DW-1:0]     type_q,
  output logic [DW-1:0]     cause_q
);
  logic [2:0]    widx;
  logic          wr_en;
  logic [DW-1:0] clr;
  logic [DW-1:0] rd_mux;

  assign widx     = addr[ADDR_W-1:2];
  assign wr_en    = sel && wr;
  assign count_wr = wr_en && (widx == W_COUNT);
  assign clr      = (wr_en && widx == W_CAUSE) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= IMPL_MASK;
      hold_q  <= IMPL_MASK;
      type_q  <= IMPL_MASK;
      cause_q <= '0;
    end else begin
      cause_q <= ((cause_q & ~clr) | set_flags) & IMPL_MASK;
      if (wr_en && widx == W_HOLD)   hold_q <= wdata & IMPL_MASK;
      if (wr_en && widx == W_ENABLE) en_q   <= wdata & IMPL_MASK;
      if (wr_en && widx == W_TYPE)   type_q <= wdata & IMPL_MASK;
    end
  end

  always_comb begin
    case (widx)
      W_CAUSE:  rd_mux = cause_q;
      W_STATUS: rd_mux = live;
      W_HOLD:   rd_mux = hold_q;
      W_ENABLE: rd_mux = en_q;
      W_TYPE:   rd_mux = type_q;
      W_COUNT:  rd_mux = count;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (sel && !wr) rdata <= rd_mux;
  end
endmodule

// File: rtl/rst_agg_seq.sv
module rst_agg_seq
  import rst_agg_pkg::*;
#(
  parameter int MIN_PULSE = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] act_en,
  input  logic [DW-1:0] hold_v,
  input  logic [DW-1:0] type_v,
  output logic [DW-1:0] set_flags,
  output logic          sys_rst_o,
  output logic          rst_hot_o
);
  localparam int PCW = $clog2(MIN_PULSE + 1);
  localparam logic [PCW-1:0] PLOAD = PCW'(MIN_PULSE - 1);

  seq_state_t     state;
  logic [PCW-1:0] pcnt;
  logic [DW-1:0]  prev_q;
  logic           fire;
  logic           held;

  assign held      = |(act_en & hold_v);
  assign fire      = (state == S_IDLE) && |(act_en & ~prev_q);
  assign set_flags = fire ? act_en : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pcnt      <= '0;
      prev_q    <= '0;
      sys_rst_o <= 1'b0;
      rst_hot_o <= 1'b0;
    end else begin
      prev_q <= act_en;
      case (state)
        S_IDLE: if (fire) begin
          state     <= S_PULSE;
          pcnt      <= PLOAD;
          sys_rst_o <= 1'b1;
          rst_hot_o <= ((act_en & ~type_v) == '0);
        end
        S_PULSE: begin
          if (pcnt != '0) pcnt <= pcnt - 1'b1;
          else if (held) state <= S_HOLD;
          else begin
            state     <= S_IDLE;
            sys_rst_o <= 1'b0;
          end
        end
        default: if (!held) begin
          state     <= S_IDLE;
          sys_rst_o <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rst_agg_ctrl.sv
module rst_agg_ctrl
  import rst_agg_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int MIN_PULSE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_tick,
  input  logic [DW-1:0]     src_req,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              sys_rst_o,
  output logic              rst_hot_o
);
  logic [DW-1:0] live_w, en_w, hold_w, typ_w, cause_w, cnt_w, setf_w;
  logic          cnt_wr_w, sw_req_w;

  always_comb begin
    live_w         = src_req & PIN_MASK;
    live_w[SW_BIT] = sw_req_w;
  end

  rst_agg_swcnt u_cnt (
    .clk(clk), .rst(rst), .tick(cnt_tick), .wr(cnt_wr_w),
    .wdata(bus_wdata), .count(cnt_w), .req(sw_req_w)
  );

  rst_agg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .live(live_w), .set_flags(setf_w), .count(cnt_w),
    .count_wr(cnt_wr_w), .rdata(bus_rdata), .en_q(en_w), .hold_q(hold_w),
    .type_q(typ_w), .cause_q(cause_w)
  );

  rst_agg_seq #(.MIN_PULSE(MIN_PULSE)) u_seq (
    .clk(clk), .rst(rst), .act_en(live_w & en_w), .hold_v(hold_w),
    .type_v(typ_w), .set_flags(setf_w), .sys_rst_o(sys_rst_o),
    .rst_hot_o(rst_hot_o)
  );
endmodule

// File: rtl/rst_agg_chk.sv
module rst_agg_chk
  import rst_agg_pkg::*;
#(
  parameter int MIN_PULSE = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sys_rst_o,
  input logic          rst_hot_o,
  input logic [DW-1:0] live,
  input logic [DW-1:0] en,
  input logic [DW-1:0] hold,
  input logic [DW-1:0] typ,
  input logic [DW-1:0] cause,
  input logic [DW-1:0] cnt,
  input logic          cnt_wr
);
  logic [31:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst) hi_len <= '0;
    else hi_len <= sys_rst_o ? hi_len + 1 : '0;
  end

  p_min_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst_o && $past(sys_rst_o)) |-> hi_len >= 32'(MIN_PULSE));

  p_enabled_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past((live & en) != '0));

  p_held_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_o && (live & en & hold) != '0) |=> sys_rst_o);

  p_cold_wins_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(sys_rst_o) && $past((live & en & ~typ) != '0)) |-> !rst_hot_o);

  p_cause_recorded_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> cause != '0);

  p_count_stops_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !cnt_wr) |=> cnt == '0);
endmodule

bind rst_agg_ctrl rst_agg_chk #(.MIN_PULSE(MIN_PULSE)) u_chk (
  .clk(clk), .rst(rst), .sys_rst_o(sys_rst_o), .rst_hot_o(rst_hot_o),
  .live(live_w), .en(en_w), .hold(hold_w), .typ(typ_w), .cause(cause_w),
  .cnt(cnt_w), .cnt_wr(cnt_wr_w)
);

// File: tb/sim_rst_agg_ctrl.sv
module sim_rst_agg_ctrl;
  localparam logic [31:0] IMPL = 32'hC10F_0F33;
  logic clk = 0, rst = 1, cnt_tick = 0;
  logic [31:0] src_req = '0;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sys_rst_o, rst_hot_o;
  int nchk = 0, nerr = 0;

  rst_agg_ctrl u0 (.clk(clk), .rst(rst), .cnt_tick(cnt_tick), .src_req(src_req),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_rst_o(sys_rst_o), .rst_hot_o(rst_hot_o));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = 5'(w * 4); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int w, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = 5'(w * 4);
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic tick1();
    cnt_tick = 1; @(negedge clk); cnt_tick = 0;
  endtask

  // counts cycles sys_rst_o stays high, starting at a negedge where it is high
  task automatic pulse_len(output int n);
    n = 0;
    while (sys_rst_o && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic quiet(input string tag, input int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (sys_rst_o) seen = 1; end
    check(tag, 32'(seen), 32'd0);
  endtask

  function automatic logic [31:0] exp_cfg(input logic [31:0] d);
    return d & IMPL;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state (R9)
    check("R9 sys_rst after por", {31'd0, sys_rst_o}, 32'd0);
    rd(3, d); check("R9 enable default", d, IMPL);
    rd(0, d); check("R9 cause default", d, 32'd0);
    rd(5, d); check("R1 reserved word 5", d, 32'd0);

    wr(2, 32'd0); // hold off everywhere
    // R4 pulse, R6 cause, R7 hot default, R10 no retrigger
    src_req = 32'h0001_0000;
    @(negedge clk);
    check("R7 hot when all hot", {31'd0, rst_hot_o}, 32'd1);
    pulse_len(n); check("R4 pulse length", 32'(n), 32'd16);
    quiet("R10 stuck source no retrigger", 12);
    src_req = '0;
    rd(0, d); check("R6 cause recorded", d, 32'h0001_0000);

    // R7 cold wins
    wr(4, IMPL & ~32'h1);
    src_req = 32'h0001_0001;
    @(negedge clk);
    check("R7 cold wins", {31'd0, rst_hot_o}, 32'd0);
    pulse_len(n);
    src_req = '0;
    rd(0, d); check("R6 cause two sources", d, 32'h0001_0001);
    wr(0, 32'h0001_0000);
    rd(0, d); check("R6 write one clears", d, 32'h0000_0001);
    wr(0, 32'h0);
    rd(0, d); check("R6 write zero no effect", d, 32'h0000_0001);

    // R3 disabled, R2 status masking
    wr(3, IMPL & ~32'h10);
    src_req = 32'h8000_0210;
    quiet("R3 disabled source no reset", 20);
    rd(1, d); check("R2 status live masked", d, 32'h0000_0010);
    rd(0, d); check("R3 cause untouched", d, 32'h0000_0001);
    src_req = '0;
    wr(3, IMPL);
    repeat (2) @(negedge clk);

    // R5 hold
    wr(2, 32'h20);
    src_req = 32'h20;
    repeat (40) @(negedge clk);
    check("R5 held past minimum", {31'd0, sys_rst_o}, 32'd1);
    src_req = '0;
    @(negedge clk);
    check("R5 release after source drops", {31'd0, sys_rst_o}, 32'd0);
    wr(2, 32'd0);

    // R8 countdown
    wr(0, IMPL);
    wr(7, 32'd5);
    tick1(); tick1();
    rd(7, d); check("R8 count after two ticks", d, 32'd3);
    tick1();
    rd(1, d); check("R2 software status at two", d, 32'h8000_0000);
    check("R8 reset at two", {31'd0, sys_rst_o}, 32'd1);
    pulse_len(n);
    rd(0, d); check("R6 software cause", d, 32'h8000_0000);
    tick1(); tick1(); tick1(); tick1();
    rd(7, d); check("R8 stops at zero", d, 32'd0);
    wr(7, 32'd4);
    tick1();
    wr(7, 32'd0);
    cnt_tick = 1;
    quiet("R8 cancel by zero", 6);
    cnt_tick = 0;
    rd(7, d); check("R9 count kept through reset", d, 32'd0);

    // R1 random config readback
    for (int i = 0; i < 24; i++) begin
      int w = 2 + int'($urandom_range(2, 0));
      logic [31:0] v = $urandom;
      wr(w, v);
      rd(w, d); check("R1 config readback", d, exp_cfg(v));
    end
    rd(6, d); check("R1 reserved word 6", d, 32'd0);

    // R9 por restores
    wr(3, 32'd0);
    rst = 1; repeat (2) @(negedge clk); rst = 0; @(negedge clk);
    rd(3, d); check("R9 enable restored", d, IMPL);
    rd(2, d); check("R9 hold restored", d, IMPL);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule